// File: doc/BRIEF.md
# Command List Sequencer with Return-Address Stack

The sequencer walks a linear list of 32-bit command words, one word per accepted handshake, and keeps its own return-address stack so a list can call shared sub-lists and come back. A start pulse begins a run at address 0. While running, the block presents a fetch address and takes the word on that address whenever the list source marks it valid. Drawing commands are not interpreted: each one leaves the block as a one-cycle pulse that carries the 28-bit payload of the word.

A run always ends with exactly one termination event. A normal end of list raises the frame-end event, but only once the external count of outstanding writes has fallen to zero. A tile-boundary command stops the run with a separate tile-end event if the tile-end request input is high at the moment it is taken. A call made with a full stack, a return made with an empty stack, and an unknown opcode each raise their own error event and end the run cleanly, as an end of list would. After any termination the block is idle, its stack is empty and it takes no input until the next start pulse.

Top module: `cmdlist_sequencer`

## Requirements
- R1: While reset is held and in the first cycle after it, busy_o and cmd_ready_o are 0, fetch_addr_o is 0 and no event output is high.
- R2: A start pulse while idle begins a run that fetches from address 0. A start pulse while busy (including while waiting for writes to drain) is ignored. A start in the same cycle as a frame-end pulse begins a new run.
- R3: A word is consumed only when cmd_valid_i and cmd_ready_o are both high. An opcode of 4 in bits [31:28] is a draw: one cycle later draw_o pulses for one cycle with draw_arg_o equal to bits [27:0], and fetching goes on at the next address. A low cmd_valid_i stalls the list with no effect.
- R4: Opcode 1 is a call: the address after the call is pushed and fetching continues at bits [ADDR_W-1:0] of the word. Opcode 2 is a return: fetching continues at the most recently pushed address. The stack holds DEPTH (default 8) entries, so 8 nested calls succeed.
- R5: A call taken while the stack already holds DEPTH entries raises stack_ovf_o and ends the run.
- R6: A return taken with an empty stack raises stack_unf_o and ends the run.
- R7: Any opcode from 5 to 15 raises bad_cmd_o and ends the run.
- R8: Opcode 0 ends the list. busy_o stays high and frame_end_o stays low while wr_pending_i is non-zero; frame_end_o pulses the cycle after wr_pending_i is first seen at zero.
- R9: Opcode 3 is a tile boundary. With tile_end_req_i high when it is taken, tile_end_o pulses and the run ends; with tile_end_req_i low it is skipped and fetching goes on at the next address.
- R10: When a termination event pulses, busy_o is already low; while idle cmd_ready_o is 0, no word is consumed and the return stack is empty, so a first return in the next run underflows.
- R11: Event outputs are one-cycle pulses, at most one of the six pulse outputs is high in any cycle, and each run raises exactly one termination event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a run at address 0 (taken only while idle) |
| cmd_valid_i | input | 1 | Command word on cmd_word_i is valid |
| cmd_ready_o | output | 1 | Sequencer will take the word this cycle |
| cmd_word_i | input | 32 | Command word read from fetch_addr_o |
| tile_end_req_i | input | 1 | Make tile-boundary commands end the run |
| wr_pending_i | input | CNT_W | Count of writes still outstanding |
| fetch_addr_o | output | ADDR_W | Address of the word to be taken next |
| busy_o | output | 1 | A run is in progress or draining |
| draw_o | output | 1 | One-cycle pulse per draw command |
| draw_arg_o | output | 28 | Payload of the last draw command |
| frame_end_o | output | 1 | One-cycle pulse: list completed and writes drained |
| tile_end_o | output | 1 | One-cycle pulse: run stopped at a tile boundary |
| stack_ovf_o | output | 1 | One-cycle pulse: call with full stack |
| stack_unf_o | output | 1 | One-cycle pulse: return with empty stack |
| bad_cmd_o | output | 1 | One-cycle pulse: unknown opcode |

## Verification
The frame-end pulse of one run and the start of the next can share a cycle: the bench raises start_i in exactly the cycle frame_end_o is seen and expects the following run to emit its draw pulse and its own frame end, while a start given earlier during the drain wait must produce no draw at all. Random lists mix calls, returns, tile markers, bad opcodes and draws under a randomly stalling valid and a randomly varying write count, and every run's draw payloads, their order and its single termination event are compared with a bench model that walks the same list.

// File: rtl/cls_pkg.sv
package cls_pkg;

    localparam int CMD_W  = 32;
    localparam int OP_LSB = 28;
    localparam int DRAW_W = OP_LSB;

    localparam logic [3:0] OP_END  = 4'd0;
    localparam logic [3:0] OP_CALL = 4'd1;
    localparam logic [3:0] OP_RET  = 4'd2;
    localparam logic [3:0] OP_TILE = 4'd3;
    localparam logic [3:0] OP_DRAW = 4'd4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_DRAIN
    } seq_state_t;

    typedef enum logic [3:0] {
        A_NEXT,
        A_CALL,
        A_RET,
        A_DRAW,
        A_END,
        A_TILE,
        A_OVF,
        A_UNF,
        A_INV
    } act_t;

    typedef struct packed {
        logic frame;
        logic tile;
        logic ovf;
        logic unf;
        logic inv;
    } evt_t;

    function automatic act_t classify(input logic [3:0] op, input logic full,
                                      input logic empty, input logic tile_req);
        act_t a;
        case (op)
            OP_END:  a = A_END;
            OP_CALL: a = full ? A_OVF : A_CALL;
            OP_RET:  a = empty ? A_UNF : A_RET;
            OP_TILE: a = tile_req ? A_TILE : A_NEXT;
            OP_DRAW: a = A_DRAW;
            default: a = A_INV;
        endcase
        return a;
    endfunction

    function automatic logic ends_run(input act_t a);
        return (a == A_END) || (a == A_TILE) || (a == A_OVF) ||
               (a == A_UNF) || (a == A_INV);
    endfunction

endpackage

// File: rtl/cls_ret_stack.sv
module cls_ret_stack #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clr,
    input  logic                         push,
    input  logic                         pop,
    input  logic [ADDR_W-1:0]            push_addr,
    output logic [ADDR_W-1:0]            top_addr,
    output logic                         full,
    output logic                         empty,
    output logic [$clog2(DEPTH+1)-1:0]   depth_o
);

    localparam int SP_W  = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [ADDR_W-1:0] mem [DEPTH];
    logic [SP_W-1:0]   sp;
    logic [SP_W-1:0]   sp_dec;

    assign sp_dec   = sp - SP_W'(1);
    assign full     = (sp == SP_W'(DEPTH));
    assign empty    = (sp == '0);
    assign top_addr = mem[sp_dec[IDX_W-1:0]];
    assign depth_o  = sp;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sp <= '0;
        end else if (push && !full) begin
            mem[sp[IDX_W-1:0]] <= push_addr;
            sp <= sp + SP_W'(1);
        end else if (pop && !empty) begin
            sp <= sp_dec;
        end
    end

endmodule

// File: rtl/cls_cmd_decode.sv
module cls_cmd_decode
    import cls_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [CMD_W-1:0]  word,
    input  logic              full,
    input  logic              empty,
    input  logic              tile_req,
    output act_t              act,
    output logic [ADDR_W-1:0] target,
    output logic [DRAW_W-1:0] payload
);

    always_comb begin
        act     = classify(word[CMD_W-1:OP_LSB], full, empty, tile_req);
        target  = word[ADDR_W-1:0];
        payload = word[DRAW_W-1:0];
    end

endmodule

// File: rtl/cmdlist_sequencer.sv
module cmdlist_sequencer
    import cls_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              cmd_valid_i,
    output logic              cmd_ready_o,
    input  logic [31:0]       cmd_word_i,
    input  logic              tile_end_req_i,
    input  logic [CNT_W-1:0]  wr_pending_i,
    output logic [ADDR_W-1:0] fetch_addr_o,
    output logic              busy_o,
    output logic              draw_o,
    output logic [27:0]       draw_arg_o,
    output logic              frame_end_o,
    output logic              tile_end_o,
    output logic              stack_ovf_o,
    output logic              stack_unf_o,
    output logic              bad_cmd_o
);

    localparam int SP_W = $clog2(DEPTH + 1);

    seq_state_t          state;
    logic [ADDR_W-1:0]   fetch_q;
    logic [ADDR_W-1:0]   next_addr;
    logic [ADDR_W-1:0]   ret_addr;
    logic [ADDR_W-1:0]   target;
    logic [DRAW_W-1:0]   payload;
    logic [DRAW_W-1:0]   draw_arg_q;
    logic                draw_q;
    evt_t                evt_q;
    act_t                act;
    logic                accept;
    logic                stk_full;
    logic                stk_empty;
    logic [SP_W-1:0]     stk_depth;

    assign accept    = (state == ST_RUN) && cmd_valid_i;
    assign next_addr = fetch_q + ADDR_W'(1);

    cls_cmd_decode #(.ADDR_W(ADDR_W)) i_decode (
        .word     (cmd_word_i),
        .full     (stk_full),
        .empty    (stk_empty),
        .tile_req (tile_end_req_i),
        .act      (act),
        .target   (target),
        .payload  (payload)
    );

    cls_ret_stack #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_stack (
        .clk       (clk),
        .rst       (rst),
        .clr       (accept && ends_run(act)),
        .push      (accept && (act == A_CALL)),
        .pop       (accept && (act == A_RET)),
        .push_addr (next_addr),
        .top_addr  (ret_addr),
        .full      (stk_full),
        .empty     (stk_empty),
        .depth_o   (stk_depth)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            fetch_q    <= '0;
            evt_q      <= '0;
            draw_q     <= 1'b0;
            draw_arg_q <= '0;
        end else begin
            evt_q  <= '0;
            draw_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        state   <= ST_RUN;
                        fetch_q <= '0;
                    end
                end
                ST_RUN: begin
                    if (accept) begin
                        case (act)
                            A_NEXT: fetch_q <= next_addr;
                            A_DRAW: begin
                                fetch_q    <= next_addr;
                                draw_q     <= 1'b1;
                                draw_arg_q <= payload;
                            end
                            A_CALL: fetch_q <= target;
                            A_RET:  fetch_q <= ret_addr;
                            A_END:  state <= ST_DRAIN;
                            A_TILE: begin
                                evt_q.tile <= 1'b1;
                                state      <= ST_IDLE;
                            end
                            A_OVF: begin
                                evt_q.ovf <= 1'b1;
                                state     <= ST_IDLE;
                            end
                            A_UNF: begin
                                evt_q.unf <= 1'b1;
                                state     <= ST_IDLE;
                            end
                            default: begin
                                evt_q.inv <= 1'b1;
                                state     <= ST_IDLE;
                            end
                        endcase
                    end
                end
                ST_DRAIN: begin
                    if (wr_pending_i == '0) begin
                        evt_q.frame <= 1'b1;
                        state       <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign cmd_ready_o  = (state == ST_RUN);
    assign busy_o       = (state != ST_IDLE);
    assign fetch_addr_o = fetch_q;
    assign draw_o       = draw_q;
    assign draw_arg_o   = draw_arg_q;
    assign frame_end_o  = evt_q.frame;
    assign tile_end_o   = evt_q.tile;
    assign stack_ovf_o  = evt_q.ovf;
    assign stack_unf_o  = evt_q.unf;
    assign bad_cmd_o    = evt_q.inv;

endmodule

// File: rtl/cls_seq_checker.sv
module cls_seq_checker #(
    parameter int DEPTH = 8,
    parameter int CNT_W = 8
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       start,
    input logic                       busy,
    input logic                       ready,
    input logic                       valid,
    input logic [CNT_W-1:0]           wr_pending,
    input logic                       draw,
    input logic                       frame,
    input logic                       tile,
    input logic                       ovf,
    input logic                       unf,
    input logic                       inv,
    input logic [$clog2(DEPTH+1)-1:0] stk_depth
);

    localparam int SP_W = $clog2(DEPTH + 1);

    logic term;
    assign term = frame | tile | ovf | unf | inv;

    AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({frame, tile, ovf, unf, inv, draw})); // R11

    AST_TERM_PULSE_SHORT: assert property (@(posedge clk) disable iff (rst)
        term |=> !term); // R11

    AST_TERM_IDLE: assert property (@(posedge clk) disable iff (rst)
        term |-> !busy); // R10

    AST_IDLE_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !ready); // R10

    AST_IDLE_STACK_EMPTY: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (stk_depth == '0)); // R10

    AST_STACK_BOUND: assert property (@(posedge clk) disable iff (rst)
        stk_depth <= SP_W'(DEPTH)); // R5

    AST_FRAME_DRAINED: assert property (@(posedge clk) disable iff (rst)
        frame |-> ($past(wr_pending) == '0)); // R8

    AST_DRAW_TAKEN: assert property (@(posedge clk) disable iff (rst)
        draw |-> $past(valid && ready)); // R3

    AST_START_RUNS: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> busy); // R2

endmodule

bind cmdlist_sequencer cls_seq_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start_i),
    .busy       (busy_o),
    .ready      (cmd_ready_o),
    .valid      (cmd_valid_i),
    .wr_pending (wr_pending_i),
    .draw       (draw_o),
    .frame      (frame_end_o),
    .tile       (tile_end_o),
    .ovf        (stack_ovf_o),
    .unf        (stack_unf_o),
    .inv        (bad_cmd_o),
    .stk_depth  (stk_depth)
);

// File: tb/test_cmdlist_sequencer.sv
`timescale 1ns/1ps
module test_cmdlist_sequencer;

    localparam int AW = 16;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          treq = 1'b0;
    logic          valid;
    logic          v_rand = 1'b0;
    logic [CW-1:0] wr;
    logic [CW-1:0] wr_rand = '0;
    logic [CW-1:0] wr_set = '0;
    int            vmode = 0;
    int            wrmode = 0;
    logic [31:0]   word;
    logic          ready, busy, draw, frame, tile, ovf, unf, inv;
    logic [AW-1:0] fetch;
    logic [27:0]   draw_arg;

    logic [31:0]   prog [64];
    logic [27:0]   exp_draw [256];
    int            nchk = 0;
    int            nerr = 0;
    bit            done = 0;

    assign word  = prog[fetch[5:0]];
    assign valid = (vmode == 1) ? 1'b1 : v_rand;
    assign wr    = (wrmode == 1) ? wr_rand : wr_set;

    cmdlist_sequencer #(.ADDR_W(AW), .DEPTH(8), .CNT_W(CW)) i_cmdlist_sequencer (
        .clk(clk), .rst(rst), .start_i(start), .cmd_valid_i(valid),
        .cmd_ready_o(ready), .cmd_word_i(word), .tile_end_req_i(treq),
        .wr_pending_i(wr), .fetch_addr_o(fetch), .busy_o(busy),
        .draw_o(draw), .draw_arg_o(draw_arg), .frame_end_o(frame),
        .tile_end_o(tile), .stack_ovf_o(ovf), .stack_unf_o(unf),
        .bad_cmd_o(inv)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        #2;
        v_rand  = ($urandom % 4) != 0;
        wr_rand = CW'($urandom % 3);
    end

    function automatic logic [31:0] mk(input int op, input int arg);
        return {4'(op), 28'(arg)};
    endfunction

    function automatic string req_of(input int t);
        case (t)
            0: return "R8";
            1: return "R9";
            2: return "R5";
            3: return "R6";
            4: return "R7";
            default: return "R11";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 64; i++) prog[i] = 32'h0;
    endtask

    task automatic model(input bit tr, output int term, output int nd);
        int a;
        int sp;
        int stk [8];
        logic [31:0] w;
        a = 0; sp = 0; nd = 0; term = -1;
        for (int s = 0; s < 600 && term < 0; s++) begin
            w = prog[a % 64];
            case (int'(w[31:28]))
                0: term = 0;
                1: if (sp == 8) term = 2;
                   else begin stk[sp] = a + 1; sp++; a = int'(w[15:0]); end
                2: if (sp == 0) term = 3;
                   else begin sp--; a = stk[sp]; end
                3: if (tr) term = 1; else a++;
                4: begin
                       if (nd < 256) exp_draw[nd] = w[27:0];
                       nd++; a++;
                   end
                default: term = 4;
            endcase
        end
        if (nd > 256) term = -1;
    endtask

    function automatic int evcount();
        return int'(frame) + int'(tile) + int'(ovf) + int'(unf) + int'(inv) + int'(draw);
    endfunction

    task automatic run_prog(input bit tr, input string dreq, input string tag);
        int eterm, endraw, gterm, gdraw, bad, multi, late;
        bit busy_at;
        model(tr, eterm, endraw);
        if (eterm < 0) return;
        treq = tr;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        gterm = -1; gdraw = 0; bad = 0; multi = 0; busy_at = 1'b1;
        for (int cyc = 0; cyc < 20000 && gterm < 0; cyc++) begin
            @(negedge clk);
            if (evcount() > 1) multi++;
            if (draw) begin
                if (gdraw >= endraw || draw_arg != exp_draw[gdraw]) bad++;
                gdraw++;
            end
            if (frame) gterm = 0;
            else if (tile) gterm = 1;
            else if (ovf) gterm = 2;
            else if (unf) gterm = 3;
            else if (inv) gterm = 4;
            busy_at = busy;
        end
        chk(gterm == eterm, req_of(eterm), {tag, " termination kind"}, gterm, eterm);
        chk(bad == 0 && gdraw == endraw, dreq, {tag, " draw payload stream"}, gdraw, endraw);
        chk(!busy_at, "R10", {tag, " idle at termination"}, int'(busy_at), 0);
        chk(multi == 0, "R11", {tag, " overlapping pulses"}, multi, 0);
        late = 0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            late += evcount();
        end
        chk(late == 0, "R11", {tag, " events after termination"}, late, 0);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL R11 watchdog expired: got %0d expected %0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        int cnt, bsy, rdy;
        void'($urandom(32'h5eed));
        clear_prog();

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!busy && !ready && fetch == '0 && evcount() == 0, "R1",
            "state under reset", int'(busy) + int'(ready), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !ready && fetch == '0 && evcount() == 0, "R1",
            "state after reset", int'(busy) + int'(ready), 0);

        // R3, R9: skipped tile marker, draws, end
        prog[0] = mk(4, 28'h0123); prog[1] = mk(3, 0);
        prog[2] = mk(4, 28'h0456); prog[3] = mk(0, 0);
        run_prog(1'b0, "R3", "R9 marker skipped");
        run_prog(1'b1, "R9", "R9 tile stop");

        // R4: call and return
        clear_prog();
        prog[0] = mk(1, 5); prog[1] = mk(4, 2); prog[2] = mk(0, 0);
        prog[5] = mk(4, 1); prog[6] = mk(2, 0);
        run_prog(1'b0, "R4", "R4 call return");

        // R4: eight nested calls unwind; R5: ninth overflows
        clear_prog();
        for (int k = 0; k < 8; k++) begin
            prog[2*k]   = mk(1, 2*k + 2);
            prog[2*k+1] = mk(2, 0);
        end
        prog[1] = mk(0, 0);
        prog[16] = mk(4, 28'h88); prog[17] = mk(2, 0);
        run_prog(1'b0, "R4", "R4 full depth");
        prog[16] = mk(1, 18);
        run_prog(1'b0, "R5", "R5 overflow");

        // R6, R7
        clear_prog();
        prog[0] = mk(4, 28'h9); prog[1] = mk(2, 0);
        run_prog(1'b0, "R6", "R6 underflow");
        prog[1] = mk(15, 0);
        run_prog(1'b0, "R7", "R7 opcode 15");
        prog[1] = mk(5, 0);
        run_prog(1'b0, "R7", "R7 opcode 5");

        // R10: stack cleared after error termination
        clear_prog();
        prog[0] = mk(1, 4); prog[4] = mk(7, 0);
        run_prog(1'b0, "R7", "R10 error with depth 1");
        prog[0] = mk(2, 0);
        run_prog(1'b0, "R10", "R10 fresh run underflows");

        // R10: input ignored while idle
        prog[0] = mk(4, 28'h33);
        vmode = 1; cnt = 0; bsy = 0; rdy = 0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            cnt += evcount(); bsy += int'(busy); rdy += int'(ready);
        end
        chk(cnt == 0 && bsy == 0 && rdy == 0, "R10", "idle ignores valid words",
            cnt + bsy + rdy, 0);
        vmode = 0;

        // R8: drain wait, R2: start ignored during drain, then coincident start
        clear_prog();
        wr_set = CW'(2);
        start = 1'b1; @(negedge clk); start = 1'b0;
        cnt = 0; bsy = 0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            cnt += int'(frame); bsy += int'(busy);
        end
        chk(cnt == 0, "R8", "frame end withheld", cnt, 0);
        chk(bsy == 8, "R8", "busy while draining", bsy, 8);
        prog[0] = mk(4, 28'h55); prog[1] = mk(0, 0);
        start = 1'b1; @(negedge clk); start = 1'b0;
        cnt = 0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            cnt += int'(draw);
        end
        chk(cnt == 0, "R2", "start during drain ignored", cnt, 0);
        wr_set = '0;
        @(negedge clk);
        chk(frame == 1'b1, "R8", "frame end after drain", int'(frame), 1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cnt = 0; bsy = 0;
        for (int k = 0; k < 200 && bsy == 0; k++) begin
            @(negedge clk);
            if (draw && draw_arg == 28'h55) cnt++;
            if (frame) bsy = 1;
        end
        chk(cnt == 1 && bsy == 1, "R2", "start coincident with frame end",
            cnt, 1);

        // random lists
        wrmode = 1;
        for (int r = 0; r < 40; r++) begin
            clear_prog();
            for (int i = 0; i < 48; i++) begin
                int s;
                s = int'($urandom % 16);
                if (s < 6 || s > 13) prog[i] = mk(4, int'($urandom));
                else if (s < 9)      prog[i] = mk(1, int'($urandom % 48));
                else if (s < 11)     prog[i] = mk(2, 0);
                else if (s == 11)    prog[i] = mk(3, 0);
                else if (s == 12)    prog[i] = mk(5 + int'($urandom % 11), 0);
                else                 prog[i] = mk(0, 0);
            end
            run_prog(1'($urandom % 2), "R3", "random list");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule